// File: doc/BRIEF.md
# Five-Bit Configuration Register with I2C Target Port

This block holds a five-bit configuration word and gives an I2C controller access to it. The target answers one fixed seven-bit address. A write transfer carries a single data byte and a read transfer returns a single data byte. The low four bits of the word feed a downstream 2-to-1 output selector. Bit 4 feeds a separately latched output. The three top bits of the byte are reserved as zero. A write-protect strap can block updates. After each accepted update the block models the programming time of non-volatile storage. For a parameterised number of clock cycles it refuses its address, so a controller polling with its address sees NACKs until the update has finished.

The block also produces an output-disable request for the downstream selector. The request rises once a write transfer's address has been acknowledged. If the transfer started a programming cycle, the request falls when that cycle ends. In every other case (protected, aborted or abandoned writes) it falls at the next START seen while no programming cycle is running. Both bus lines are sampled by the system clock through a synchroniser. SDA is driven open-drain through an active-high pull-low enable. The write-protect input is taken as a static strap that is synchronous to the clock.

Top module: `cfg5_i2c_target`

## Requirements
- R1: After reset the configuration word is 0, the output-disable request is 0 and SDA is not pulled low.
- R2: The target acknowledges an address byte whose seven upper bits are 1001110, sent MSB first, with bit 0 giving the direction (0 = write, 1 = read). Any other address is not acknowledged, and the target then pulls SDA low for no bit until the next START.
- R3: In a write transfer the data byte is acknowledged. When write-protect is 0 and bits 7..5 of the byte are all 0, the configuration word takes bits 4..0 of the byte.
- R4: A write made while write-protect is 1 leaves the configuration word unchanged.
- R5: A write whose data bits 7..5 are not all 0 leaves the configuration word unchanged and starts no programming cycle, so the address is acknowledged again straight away.
- R6: A read transfer returns one byte, MSB first: three zero bits followed by the configuration word.
- R7: For BUSY_CYCLES clocks after an update is accepted, the target does not acknowledge its own address.
- R8: The output-disable request rises after the address of a write transfer is acknowledged. When an update was accepted, the request stays high through the whole programming cycle (a START during that cycle does not clear it) and falls when the cycle ends.
- R9: When a write transfer starts no programming cycle (protected or aborted), the output-disable request stays high until the next START and falls on it.
- R10: A START or STOP in the middle of a byte abandons the transfer without changing the configuration word, and the target is ready for a fresh address byte.
- R11: A read transfer does not raise the output-disable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| writeProtect | input | 1 | 1 blocks updates of the configuration word |
| sdaDriveLow | output | 1 | 1 enables the open-drain pull-down on SDA |
| cfgOut | output | 5 | Configuration word: bit 4 for the latched output, bits 3..0 for the selector |
| outDisable | output | 1 | Request to the output selector to disable its outputs |

## Verification
A wrong state in the bus sequencer shows up at the very next acknowledge slot: SDA is pulled low where it should be released, or released where it should be pulled low, and a read presents shifted or stale data bits. A wrong busy counter shows in two ways. The address NACK window is cut short or stretched, and the disable request falls too early or too late, which can be seen within a few thousand clocks of the update. A wrong write gate shows at cfgOut within a few clocks of the eighth data bit, and the reference model compares cfgOut against its own copy on every clock while the bus is outside that edge.

// File: rtl/cfg5_pkg.sv
package cfg5_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic              startSeen;
    logic              armDisable;
    logic              commitWrite;
    logic              loadRead;
    logic              shiftRead;
    logic [BYTE_W-1:0] wrData;
  } ctrlStrb_t;
endpackage

// File: rtl/cfg5_ctrl.sv
module cfg5_ctrl
  import cfg5_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1001110
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      busyIn,
  input  logic      rdBit,
  output ctrlStrb_t strb,
  output logic      sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclS, sclPrev, sdaS, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic rwBit;
  logic byteDone;

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sclPrev  = sclPipe[SYNC_STAGES];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev  = sdaPipe[SYNC_STAGES];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      rwBit   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            rxShift <= {rxShift[BYTE_W-2:0], sdaS};
            bitCnt  <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            if (state == ST_WDATA) begin
              state <= ST_WACK;
            end else if (rxShift[BYTE_W-1:1] == DEV_ADDR && !busyIn) begin
              state <= ST_AACK;
              rwBit <= rxShift[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= rwBit ? ST_RDATA : ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && byteDone) state <= ST_RACK;
        end
        ST_WACK, ST_RACK: begin
          if (sclFall) state <= ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    logic quiet;
    quiet            = !startDet && !stopDet;
    strb.startSeen   = startDet;
    strb.armDisable  = quiet && state == ST_AACK && sclFall && !rwBit;
    strb.loadRead    = quiet && state == ST_AACK && sclFall && rwBit;
    strb.shiftRead   = quiet && state == ST_RDATA && sclFall && !byteDone;
    strb.commitWrite = quiet && state == ST_WDATA && sclFall && byteDone;
    strb.wrData      = rxShift;
  end

  assign sdaDriveLow = (state == ST_AACK) || (state == ST_WACK) ||
                       (state == ST_RDATA && !rdBit);

  assert_ack_own_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AACK) |-> (rxShift[BYTE_W-1:1] == DEV_ADDR));

  assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteDone && busyIn) |=> (state != ST_AACK));

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);
endmodule

// File: rtl/cfg5_data.sv
module cfg5_data
  import cfg5_pkg::*;
#(
  parameter int DATA_W      = 5,
  parameter int BUSY_CYCLES = 1500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              writeProtect,
  output logic [DATA_W-1:0] cfgOut,
  output logic              outDisable,
  output logic              busy,
  output logic              rdBit
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int PAD_W = BYTE_W - DATA_W;

  logic [DATA_W-1:0] cfgReg;
  logic [CNT_W-1:0]  busyCnt;
  logic [BYTE_W-1:0] rdShift;
  logic              accept;
  logic              cycleEnd;

  assign accept   = strb.commitWrite && !writeProtect &&
                    (strb.wrData[BYTE_W-1:DATA_W] == '0);
  assign cycleEnd = (busyCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      busyCnt <= '0;
    end else if (accept) begin
      cfgReg  <= strb.wrData[DATA_W-1:0];
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outDisable <= 1'b0;
    end else if (strb.armDisable) begin
      outDisable <= 1'b1;
    end else if (cycleEnd || (strb.startSeen && busyCnt == '0)) begin
      outDisable <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdShift <= '0;
    else if (strb.loadRead) rdShift <= {{PAD_W{1'b0}}, cfgReg};
    else if (strb.shiftRead) rdShift <= {rdShift[BYTE_W-2:0], 1'b0};
  end

  assign cfgOut = cfgReg;
  assign busy   = (busyCnt != '0);
  assign rdBit  = rdShift[BYTE_W-1];

  assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && writeProtect) |=> $stable(cfgReg));

  assert_abort_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && strb.wrData[BYTE_W-1:DATA_W] != '0) |=> $stable(cfgReg));

  assert_dis_covers_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0) |-> outDisable);

  assert_dis_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outDisable) |-> ($past(busyCnt) == CNT_W'(1) || $past(strb.startSeen)));
endmodule

// File: rtl/cfg5_i2c_target.sv
module cfg5_i2c_target
  import cfg5_pkg::*;
#(
  parameter int         DATA_W      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 1500000,
  parameter logic [6:0] DEV_ADDR    = 7'b1001110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              writeProtect,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] cfgOut,
  output logic              outDisable
);
  ctrlStrb_t strb;
  logic busy, rdBit;

  cfg5_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .busyIn(busy), .rdBit(rdBit), .strb(strb), .sdaDriveLow(sdaDriveLow)
  );

  cfg5_data #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .writeProtect(writeProtect),
    .cfgOut(cfgOut), .outDisable(outDisable), .busy(busy), .rdBit(rdBit)
  );
endmodule

// File: tb/cfg5_i2c_target_tb_top.sv
module cfg5_i2c_target_tb_top;
  localparam int BUSY = 2000;
  localparam int Q    = 10;
  localparam logic [6:0] ADDR = 7'b1001110;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic sdaDriveLow, outDisable;
  logic [4:0] cfgOut;
  wire sdaBus = sdaM & ~sdaDriveLow;

  int errors = 0, checks = 0;
  bit cmpEn = 1'b0, done = 1'b0;
  logic [4:0] expCfg = '0;

  always #5 clk = ~clk;

  cfg5_i2c_target #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .writeProtect(wp), .sdaDriveLow(sdaDriveLow), .cfgOut(cfgOut),
    .outDisable(outDisable)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the configuration word against the model (R3 R4 R5 R10)
  always @(negedge clk)
    if (cmpEn && rstN) chk("R3/R4/R5/R10 model", cfgOut === expCfg, cfgOut, expCfg);

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; w(Q); sclM = 1'b1; w(2*Q); sclM = 1'b0; w(Q);
  endtask

  task automatic readBit(output logic v);
    sdaM = 1'b1; w(Q); sclM = 1'b1; w(Q); v = sdaBus; w(Q); sclM = 1'b0; w(Q);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; w(Q); sclM = 1'b1; w(Q); sdaM = 1'b0; w(Q); sclM = 1'b0; w(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; w(Q); sclM = 1'b1; w(Q); sdaM = 1'b1; w(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    readBit(v);
    ack = ~v;
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) readBit(b[i]);
    sendBit(1'b1);
  endtask

  task automatic writeTx(input logic [6:0] a, input logic [7:0] d,
                         output logic aAck, output logic dAck);
    i2cStart();
    sendByte({a, 1'b0}, aAck);
    cmpEn = 1'b0;
    sendByte(d, dAck);
    i2cStop();
    if (aAck && !wp && d[7:5] == 3'b000) expCfg = d[4:0];
    cmpEn = 1'b1;
  endtask

  task automatic readTx(output logic aAck, output logic [7:0] d);
    i2cStart();
    sendByte({ADDR, 1'b1}, aAck);
    d = 8'hxx;
    if (aAck) recvByte(d);
    i2cStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a, d;
    logic [7:0] rd;
    w(5); rstN = 1'b1; w(5);
    chk("R1 cfg reset", cfgOut == 5'h00, cfgOut, 0);
    chk("R1 disable reset", outDisable == 1'b0, outDisable, 0);
    chk("R1 sda released", sdaDriveLow == 1'b0, sdaDriveLow, 0);
    cmpEn = 1'b1;

    readTx(a, rd);
    chk("R2 read addr ack", a == 1'b1, a, 1);
    chk("R6 read default", rd == 8'h00, rd, 8'h00);
    chk("R11 no disable on read", outDisable == 1'b0, outDisable, 0);

    writeTx(ADDR, 8'h15, a, d);
    chk("R2 write addr ack", a == 1'b1, a, 1);
    chk("R3 data ack", d == 1'b1, d, 1);
    chk("R3 cfg updated", cfgOut == 5'h15, cfgOut, 5'h15);
    chk("R8 disable raised", outDisable == 1'b1, outDisable, 1);

    readTx(a, rd);
    chk("R7 nack while busy", a == 1'b0, a, 0);
    chk("R8 start in cycle keeps disable", outDisable == 1'b1, outDisable, 1);
    w(BUSY + 200);
    chk("R8 disable fell after cycle", outDisable == 1'b0, outDisable, 0);
    readTx(a, rd);
    chk("R7 ack after cycle", a == 1'b1, a, 1);
    chk("R6 read value", rd == 8'h15, rd, 8'h15);

    wp = 1'b1;
    writeTx(ADDR, 8'h0A, a, d);
    chk("R4 addr ack protected", a == 1'b1, a, 1);
    chk("R4 cfg kept", cfgOut == 5'h15, cfgOut, 5'h15);
    w(BUSY + 200);
    chk("R9 disable held until start", outDisable == 1'b1, outDisable, 1);
    wp = 1'b0;
    readTx(a, rd);
    chk("R4 read after protected", rd == 8'h15, rd, 8'h15);
    chk("R9 disable fell at start", outDisable == 1'b0, outDisable, 0);

    writeTx(ADDR, 8'h2F, a, d);
    chk("R5 cfg kept on abort", cfgOut == 5'h15, cfgOut, 5'h15);
    chk("R9 disable held after abort", outDisable == 1'b1, outDisable, 1);
    readTx(a, rd);
    chk("R5 no cycle after abort", a == 1'b1, a, 1);
    chk("R5 read after abort", rd == 8'h15, rd, 8'h15);
    chk("R9 disable fell after abort", outDisable == 1'b0, outDisable, 0);

    writeTx(7'b1001111, 8'h03, a, d);
    chk("R2 foreign addr nack", a == 1'b0, a, 0);
    chk("R2 foreign data nack", d == 1'b0, d, 0);
    chk("R2 foreign no disable", outDisable == 1'b0, outDisable, 0);

    i2cStart();
    sendByte({ADDR, 1'b0}, a);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    readTx(a, rd);
    chk("R10 ack after restart", a == 1'b1, a, 1);
    chk("R10 read after restart", rd == 8'h15, rd, 8'h15);
    chk("R10 disable released", outDisable == 1'b0, outDisable, 0);
    i2cStart();
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    i2cStop();
    readTx(a, rd);
    chk("R10 ack after stop", a == 1'b1, a, 1);

    writeTx(ADDR, 8'h1F, a, d);
    w(BUSY + 200);
    readTx(a, rd);
    chk("R6 read all ones", rd == 8'h1F, rd, 8'h1F);
    writeTx(ADDR, 8'h00, a, d);
    chk("R3 cfg cleared", cfgOut == 5'h00, cfgOut, 0);
    w(BUSY + 200);
    readTx(a, rd);
    chk("R6 read cleared", rd == 8'h00, rd, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule